// File: doc/BRIEF.md
# Boundary-Scan Cell Chain with Bidirectional Pins

This block is the serial test register that wraps a small group of device pins. It has three kinds of pin. Input pins only carry an observe cell. Output pins are grouped, and each group shares one enable cell. Each bidirectional pin has a data cell and an enable cell of its own. The test access controller supplies the capture, shift and update strobes, the serial input bit and a 2-bit instruction mode. The block returns the serial output bit and the values and enables presented to the pads.

On a capture strobe every cell loads a parallel value: the pin level for input and bidirectional cells, and the core's value for output and enable cells. A shift strobe moves the chain one place toward the serial output. An update strobe copies the shift stages of the output and enable cells into update latches. In the pin-driving modes those latches own the pads. In the other modes the core owns the pads. Enable cells are active-low disables: a latched 1 puts the pins it guards into high impedance. All state runs on the test clock. The test reset is asynchronous on assertion and is released through a two-stage synchronizer.

Top module: `bsr_chain`

## Requirements
- R1: The chain holds CHAIN_LEN = N_GRP*(GRP_W+1) + 2*N_BI + N_IN cells, and `tdo` always shows cell 0. Cell positions are as follows. Group g's enable cell is at g*(GRP_W+1), and output pin p is at (p/GRP_W)*(GRP_W+1)+1+(p%GRP_W). Bidirectional pin b has its enable cell at N_GRP*(GRP_W+1)+2b and its data cell one position above. Input pin i is at N_GRP*(GRP_W+1)+2*N_BI+i. A shift edge moves every cell one index down and loads `tdi` into the top cell, so the bit sent first leaves `tdo` CHAIN_LEN shifts later.
- R2: A capture edge loads the following values, whatever the mode, and takes priority over a shift in the same cycle. Input cells take `in_pin`. Output cells take `core_out`. Group enable cells take the inverse of `core_out_en`. Bidirectional enable cells take the inverse of `core_bi_en`.
- R3: The update latches change only on an update edge. The pads therefore hold steady while the chain shifts or captures.
- R4: `test_mode` is encoded as 0 = external test, 1 = sample, 2 = self-test and 3 = functional. In modes 0 and 2, each pad value comes from its data latch, and each pad enable is the inverse of its enable latch.
- R5: All GRP_W pins of one output group share one enable, so their enables are always equal.
- R6: In modes 1 and 3 the pads carry the core's values and enables unchanged. Update edges still load the latches in these modes, so a later switch to mode 0 drives what was loaded.
- R7: While the test reset is low, or right after it, every shift stage is 0 and every data latch is 0. Every enable latch is 1, so in modes 0 and 2 all pads are disabled and drive 0 until the first update.
- R8: A bidirectional data cell captures the level on `bi_in`, including in mode 0 while the same pin is being driven from its latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Test reset, active low, asynchronous assert |
| cap_en | input | 1 | Capture strobe |
| shf_en | input | 1 | Shift strobe |
| upd_en | input | 1 | Update strobe |
| test_mode | input | 2 | Instruction mode (0 ext test, 1 sample, 2 self-test, 3 functional) |
| tdi | input | 1 | Serial input into the top cell |
| tdo | output | 1 | Serial output from cell 0 |
| core_out | input | N_GRP*GRP_W | Core values for output pins |
| core_out_en | input | N_GRP | Core enables per output group, 1 = drive |
| out_pin | output | N_GRP*GRP_W | Values presented to output pads |
| out_oe | output | N_GRP*GRP_W | Output pad enables, 1 = drive |
| core_bi_out | input | N_BI | Core values for bidirectional pins |
| core_bi_en | input | N_BI | Core enables for bidirectional pins, 1 = drive |
| bi_in | input | N_BI | Levels received from bidirectional pads |
| bi_pin_out | output | N_BI | Values presented to bidirectional pads |
| bi_oe | output | N_BI | Bidirectional pad enables, 1 = drive |
| in_pin | input | N_IN | Levels on input-only pads |

## Verification
The pad outputs are combinational in the mode and the latches. The bench therefore checks them in the same cycle as a mode change, and on the falling edge right after an update edge. After a capture edge, cell k reaches `tdo` after k further shift edges. The bench reads `tdo` on each falling edge before it drives the next shift, so the k-th read is captured cell k. Reset takes effect at once, and release takes two test-clock edges. The bench waits three edges before it drives any strobe.

// File: rtl/bsr_pkg.sv
package bsr_pkg;

  typedef enum logic [1:0] {
    MODE_EXTEST   = 2'd0,
    MODE_SAMPLE   = 2'd1,
    MODE_SELFTEST = 2'd2,
    MODE_FUNC     = 2'd3
  } bsr_mode_e;

  typedef enum logic [2:0] {
    CK_GCTL = 3'd0,
    CK_OUT  = 3'd1,
    CK_BCTL = 3'd2,
    CK_BIO  = 3'd3,
    CK_IN   = 3'd4
  } cell_kind_e;

  function automatic logic test_drives(input logic [1:0] m);
    return (m == MODE_EXTEST) || (m == MODE_SELFTEST);
  endfunction

  function automatic int out_span(input int ngrp, input int gw);
    return ngrp * (gw + 1);
  endfunction

  function automatic int gctl_pos(input int g, input int gw);
    return g * (gw + 1);
  endfunction

  function automatic int opin_pos(input int p, input int gw);
    return (p / gw) * (gw + 1) + 1 + (p % gw);
  endfunction

  function automatic int bctl_pos(input int b, input int ngrp, input int gw);
    return out_span(ngrp, gw) + 2 * b;
  endfunction

  function automatic int bio_pos(input int b, input int ngrp, input int gw);
    return out_span(ngrp, gw) + 2 * b + 1;
  endfunction

  function automatic int in_pos(input int i, input int ngrp, input int gw, input int nbi);
    return out_span(ngrp, gw) + 2 * nbi + i;
  endfunction

  function automatic cell_kind_e kind_of(input int idx, input int ngrp, input int gw, input int nbi);
    int span;
    span = out_span(ngrp, gw);
    if (idx < span) begin
      if ((idx % (gw + 1)) == 0) return CK_GCTL;
      return CK_OUT;
    end
    if (idx < span + 2 * nbi) begin
      if (((idx - span) % 2) == 0) return CK_BCTL;
      return CK_BIO;
    end
    return CK_IN;
  endfunction

  function automatic int slot_of(input int idx, input int ngrp, input int gw, input int nbi);
    int span;
    int r;
    span = out_span(ngrp, gw);
    if (idx < span) begin
      r = idx % (gw + 1);
      if (r == 0) return idx / (gw + 1);
      return (idx / (gw + 1)) * gw + r - 1;
    end
    if (idx < span + 2 * nbi) return (idx - span) / 2;
    return idx - span - 2 * nbi;
  endfunction

endpackage

// File: rtl/bsr_rst_sync.sv
module bsr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) stage_q <= 2'b00;
    else         stage_q <= stage_d;
  end

  assign rst_n_o = stage_q[1];
endmodule

// File: rtl/bsr_capture_sel.sv
module bsr_capture_sel
  import bsr_pkg::*;
#(
  parameter int N_GRP = 2,
  parameter int GRP_W = 2,
  parameter int N_BI  = 2,
  parameter int N_IN  = 3,
  localparam int N_OUT = N_GRP * GRP_W,
  localparam int LEN   = N_GRP * (GRP_W + 1) + 2 * N_BI + N_IN
) (
  input  logic [N_OUT-1:0] core_out,
  input  logic [N_GRP-1:0] core_out_en,
  input  logic [N_BI-1:0]  core_bi_en,
  input  logic [N_BI-1:0]  bi_in,
  input  logic [N_IN-1:0]  in_pin,
  output logic [LEN-1:0]   cap_vec
);
  for (genvar c = 0; c < LEN; c++) begin : g_cell
    localparam cell_kind_e KIND = kind_of(c, N_GRP, GRP_W, N_BI);
    localparam int         SLOT = slot_of(c, N_GRP, GRP_W, N_BI);
    if (KIND == CK_GCTL) begin : g_gctl
      assign cap_vec[c] = ~core_out_en[SLOT];
    end else if (KIND == CK_OUT) begin : g_out
      assign cap_vec[c] = core_out[SLOT];
    end else if (KIND == CK_BCTL) begin : g_bctl
      assign cap_vec[c] = ~core_bi_en[SLOT];
    end else if (KIND == CK_BIO) begin : g_bio
      assign cap_vec[c] = bi_in[SLOT];
    end else begin : g_in
      assign cap_vec[c] = in_pin[SLOT];
    end
  end
endmodule

// File: rtl/bsr_shift_chain.sv
module bsr_shift_chain #(
  parameter int LEN = 13
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cap_en,
  input  logic           shf_en,
  input  logic           tdi,
  input  logic [LEN-1:0] cap_vec,
  output logic [LEN-1:0] sr_q,
  output logic           tdo
);
  logic [LEN-1:0] sr_d;

  always_comb begin
    sr_d = sr_q;
    if (cap_en)      sr_d = cap_vec;
    else if (shf_en) sr_d = {tdi, sr_q[LEN-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= sr_d;
  end

  assign tdo = sr_q[0];
endmodule

// File: rtl/bsr_update_bank.sv
module bsr_update_bank
  import bsr_pkg::*;
#(
  parameter int N_GRP = 2,
  parameter int GRP_W = 2,
  parameter int N_BI  = 2,
  localparam int N_LAT = N_GRP * (GRP_W + 1) + 2 * N_BI
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_en,
  input  logic [N_LAT-1:0] sr_par,
  output logic [N_LAT-1:0] upd_q
);
  for (genvar c = 0; c < N_LAT; c++) begin : g_lat
    localparam cell_kind_e KIND  = kind_of(c, N_GRP, GRP_W, N_BI);
    localparam logic       RST_V = (KIND == CK_GCTL) || (KIND == CK_BCTL);
    logic lat_d;

    always_comb lat_d = upd_en ? sr_par[c] : upd_q[c];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) upd_q[c] <= RST_V;
      else        upd_q[c] <= lat_d;
    end
  end
endmodule

// File: rtl/bsr_pin_mux.sv
module bsr_pin_mux
  import bsr_pkg::*;
#(
  parameter int N_GRP = 2,
  parameter int GRP_W = 2,
  parameter int N_BI  = 2,
  localparam int N_OUT = N_GRP * GRP_W,
  localparam int N_LAT = N_GRP * (GRP_W + 1) + 2 * N_BI
) (
  input  logic [1:0]       test_mode,
  input  logic [N_LAT-1:0] upd_q,
  input  logic [N_OUT-1:0] core_out,
  input  logic [N_GRP-1:0] core_out_en,
  input  logic [N_BI-1:0]  core_bi_out,
  input  logic [N_BI-1:0]  core_bi_en,
  output logic [N_OUT-1:0] out_pin,
  output logic [N_OUT-1:0] out_oe,
  output logic [N_BI-1:0]  bi_pin_out,
  output logic [N_BI-1:0]  bi_oe
);
  logic drive_sel;
  assign drive_sel = test_drives(test_mode);

  for (genvar p = 0; p < N_OUT; p++) begin : g_opin
    localparam int DPOS = opin_pos(p, GRP_W);
    localparam int CPOS = gctl_pos(p / GRP_W, GRP_W);
    always_comb begin
      if (drive_sel) begin
        out_pin[p] = upd_q[DPOS];
        out_oe[p]  = ~upd_q[CPOS];
      end else begin
        out_pin[p] = core_out[p];
        out_oe[p]  = core_out_en[p / GRP_W];
      end
    end
  end

  for (genvar b = 0; b < N_BI; b++) begin : g_bpin
    localparam int DPOS = bio_pos(b, N_GRP, GRP_W);
    localparam int CPOS = bctl_pos(b, N_GRP, GRP_W);
    always_comb begin
      if (drive_sel) begin
        bi_pin_out[b] = upd_q[DPOS];
        bi_oe[b]      = ~upd_q[CPOS];
      end else begin
        bi_pin_out[b] = core_bi_out[b];
        bi_oe[b]      = core_bi_en[b];
      end
    end
  end
endmodule

// File: rtl/bsr_chain.sv
module bsr_chain #(
  parameter int N_GRP = 2,
  parameter int GRP_W = 2,
  parameter int N_BI  = 2,
  parameter int N_IN  = 3,
  localparam int N_OUT     = N_GRP * GRP_W,
  localparam int N_LAT     = N_GRP * (GRP_W + 1) + 2 * N_BI,
  localparam int CHAIN_LEN = N_LAT + N_IN
) (
  input  logic             tck,
  input  logic             trst_n,
  input  logic             cap_en,
  input  logic             shf_en,
  input  logic             upd_en,
  input  logic [1:0]       test_mode,
  input  logic             tdi,
  output logic             tdo,
  input  logic [N_OUT-1:0] core_out,
  input  logic [N_GRP-1:0] core_out_en,
  output logic [N_OUT-1:0] out_pin,
  output logic [N_OUT-1:0] out_oe,
  input  logic [N_BI-1:0]  core_bi_out,
  input  logic [N_BI-1:0]  core_bi_en,
  input  logic [N_BI-1:0]  bi_in,
  output logic [N_BI-1:0]  bi_pin_out,
  output logic [N_BI-1:0]  bi_oe,
  input  logic [N_IN-1:0]  in_pin
);
  logic                 rst_sync_n;
  logic [CHAIN_LEN-1:0] cap_vec;
  logic [CHAIN_LEN-1:0] sr_q;
  logic [N_LAT-1:0]     upd_q;

  bsr_rst_sync u_rst (
    .clk     (tck),
    .arst_n  (trst_n),
    .rst_n_o (rst_sync_n)
  );

  bsr_capture_sel #(
    .N_GRP (N_GRP), .GRP_W (GRP_W), .N_BI (N_BI), .N_IN (N_IN)
  ) u_cap (
    .core_out    (core_out),
    .core_out_en (core_out_en),
    .core_bi_en  (core_bi_en),
    .bi_in       (bi_in),
    .in_pin      (in_pin),
    .cap_vec     (cap_vec)
  );

  bsr_shift_chain #(.LEN (CHAIN_LEN)) u_sr (
    .clk     (tck),
    .rst_n   (rst_sync_n),
    .cap_en  (cap_en),
    .shf_en  (shf_en),
    .tdi     (tdi),
    .cap_vec (cap_vec),
    .sr_q    (sr_q),
    .tdo     (tdo)
  );

  bsr_update_bank #(.N_GRP (N_GRP), .GRP_W (GRP_W), .N_BI (N_BI)) u_upd (
    .clk    (tck),
    .rst_n  (rst_sync_n),
    .upd_en (upd_en),
    .sr_par (sr_q[N_LAT-1:0]),
    .upd_q  (upd_q)
  );

  bsr_pin_mux #(.N_GRP (N_GRP), .GRP_W (GRP_W), .N_BI (N_BI)) u_mux (
    .test_mode   (test_mode),
    .upd_q       (upd_q),
    .core_out    (core_out),
    .core_out_en (core_out_en),
    .core_bi_out (core_bi_out),
    .core_bi_en  (core_bi_en),
    .out_pin     (out_pin),
    .out_oe      (out_oe),
    .bi_pin_out  (bi_pin_out),
    .bi_oe       (bi_oe)
  );
endmodule

// File: rtl/bsr_chain_chk.sv
module bsr_chain_chk
  import bsr_pkg::*;
#(
  parameter int N_GRP = 2,
  parameter int GRP_W = 2,
  parameter int N_BI  = 2,
  parameter int N_IN  = 3,
  localparam int N_OUT     = N_GRP * GRP_W,
  localparam int N_LAT     = N_GRP * (GRP_W + 1) + 2 * N_BI,
  localparam int CHAIN_LEN = N_LAT + N_IN
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cap_en,
  input logic                 shf_en,
  input logic                 upd_en,
  input logic [1:0]           test_mode,
  input logic                 tdi,
  input logic [N_IN-1:0]      in_pin,
  input logic [N_BI-1:0]      bi_in,
  input logic [CHAIN_LEN-1:0] sr_q,
  input logic [N_LAT-1:0]     upd_q,
  input logic [N_OUT-1:0]     core_out,
  input logic [N_BI-1:0]      core_bi_out,
  input logic [N_OUT-1:0]     out_pin,
  input logic [N_OUT-1:0]     out_oe,
  input logic [N_BI-1:0]      bi_pin_out,
  input logic [N_BI-1:0]      bi_oe
);
  logic drv;
  logic upd_seen_q;

  assign drv = test_drives(test_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      upd_seen_q <= 1'b0;
    else if (upd_en) upd_seen_q <= 1'b1;
  end

  // R1
  shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shf_en && !cap_en) |=> (sr_q[CHAIN_LEN-2:0] == $past(sr_q[CHAIN_LEN-1:1])
                             && sr_q[CHAIN_LEN-1] == $past(tdi)));

  // R3
  pad_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_en && drv) ##1 drv |-> ($stable(out_pin) && $stable(out_oe)
                                  && $stable(bi_pin_out) && $stable(bi_oe)));

  // R6
  func_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drv |-> (out_pin == core_out && bi_pin_out == core_bi_out));

  // R7
  reset_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drv && !upd_seen_q) |-> (out_oe == '0 && bi_oe == '0));

  for (genvar i = 0; i < N_IN; i++) begin : g_in_chk
    // R2
    in_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en |=> sr_q[in_pos(i, N_GRP, GRP_W, N_BI)] == $past(in_pin[i]));
  end

  for (genvar b = 0; b < N_BI; b++) begin : g_bi_chk
    // R8
    bi_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en |=> sr_q[bio_pos(b, N_GRP, GRP_W)] == $past(bi_in[b]));
    // R4
    bi_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drv |-> (bi_pin_out[b] == upd_q[bio_pos(b, N_GRP, GRP_W)]
               && bi_oe[b] == !upd_q[bctl_pos(b, N_GRP, GRP_W)]));
  end

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp_chk
    // R5
    group_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(out_oe[g*GRP_W +: GRP_W]) == 0
       || $countones(out_oe[g*GRP_W +: GRP_W]) == GRP_W));
  end
endmodule

bind bsr_chain bsr_chain_chk #(
  .N_GRP (N_GRP), .GRP_W (GRP_W), .N_BI (N_BI), .N_IN (N_IN)
) u_chk (
  .clk         (tck),
  .rst_n       (rst_sync_n),
  .cap_en      (cap_en),
  .shf_en      (shf_en),
  .upd_en      (upd_en),
  .test_mode   (test_mode),
  .tdi         (tdi),
  .in_pin      (in_pin),
  .bi_in       (bi_in),
  .sr_q        (sr_q),
  .upd_q       (upd_q),
  .core_out    (core_out),
  .core_bi_out (core_bi_out),
  .out_pin     (out_pin),
  .out_oe      (out_oe),
  .bi_pin_out  (bi_pin_out),
  .bi_oe       (bi_oe)
);

// File: tb/sim_bsr_chain.sv
module sim_bsr_chain;
  localparam int NG   = 2;
  localparam int GW   = 2;
  localparam int NB   = 2;
  localparam int NI   = 3;
  localparam int NO   = NG * GW;
  localparam int SPAN = NG * (GW + 1);
  localparam int L    = SPAN + 2 * NB + NI;
  localparam int PW   = 2 * NO + 2 * NB;

  logic tck = 1'b0;
  logic trst_n, cap_en, shf_en, upd_en, tdi, tdo;
  logic [1:0] test_mode;
  logic [NO-1:0] core_out, out_pin, out_oe;
  logic [NG-1:0] core_out_en;
  logic [NB-1:0] core_bi_out, core_bi_en, bi_in, bi_pin_out, bi_oe;
  logic [NI-1:0] in_pin;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #10 tck = ~tck;

  bsr_chain #(.N_GRP (NG), .GRP_W (GW), .N_BI (NB), .N_IN (NI)) u0 (
    .tck (tck), .trst_n (trst_n), .cap_en (cap_en), .shf_en (shf_en),
    .upd_en (upd_en), .test_mode (test_mode), .tdi (tdi), .tdo (tdo),
    .core_out (core_out), .core_out_en (core_out_en), .out_pin (out_pin),
    .out_oe (out_oe), .core_bi_out (core_bi_out), .core_bi_en (core_bi_en),
    .bi_in (bi_in), .bi_pin_out (bi_pin_out), .bi_oe (bi_oe), .in_pin (in_pin)
  );

  function automatic int p_gctl(int g); return g * (GW + 1); endfunction
  function automatic int p_opin(int p); return (p / GW) * (GW + 1) + 1 + (p % GW); endfunction
  function automatic int p_bctl(int b); return SPAN + 2 * b; endfunction
  function automatic int p_bio(int b);  return SPAN + 2 * b + 1; endfunction
  function automatic int p_in(int i);   return SPAN + 2 * NB + i; endfunction

  function automatic logic [31:0] mix(int x);
    logic [31:0] v;
    v = 32'(x) * 32'h9E3779B1;
    v = v ^ (v >> 15);
    v = v * 32'h85EBCA6B;
    v = v ^ (v >> 13);
    return v;
  endfunction

  function automatic logic [L-1:0] ctrl_mask();
    logic [L-1:0] v = '0;
    for (int g = 0; g < NG; g++) v[p_gctl(g)] = 1'b1;
    for (int b = 0; b < NB; b++) v[p_bctl(b)] = 1'b1;
    return v;
  endfunction

  function automatic logic [L-1:0] exp_cap();
    logic [L-1:0] v = '0;
    for (int g = 0; g < NG; g++) v[p_gctl(g)] = ~core_out_en[g];
    for (int p = 0; p < NO; p++) v[p_opin(p)] = core_out[p];
    for (int b = 0; b < NB; b++) begin
      v[p_bctl(b)] = ~core_bi_en[b];
      v[p_bio(b)]  = bi_in[b];
    end
    for (int i = 0; i < NI; i++) v[p_in(i)] = in_pin[i];
    return v;
  endfunction

  function automatic logic [PW-1:0] exp_pads(logic [L-1:0] lat, logic [1:0] m);
    logic [NO-1:0] op, oe;
    logic [NB-1:0] bp, be;
    for (int p = 0; p < NO; p++) begin
      op[p] = (m == 2'd0 || m == 2'd2) ? lat[p_opin(p)] : core_out[p];
      oe[p] = (m == 2'd0 || m == 2'd2) ? ~lat[p_gctl(p / GW)] : core_out_en[p / GW];
    end
    for (int b = 0; b < NB; b++) begin
      bp[b] = (m == 2'd0 || m == 2'd2) ? lat[p_bio(b)] : core_bi_out[b];
      be[b] = (m == 2'd0 || m == 2'd2) ? ~lat[p_bctl(b)] : core_bi_en[b];
    end
    return {op, oe, bp, be};
  endfunction

  function automatic logic [PW-1:0] pads();
    return {out_pin, out_oe, bi_pin_out, bi_oe};
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge tck);
    @(negedge tck);
  endtask

  task automatic set_pins(int seed);
    logic [31:0] h;
    h = mix(seed);
    core_out    = h[NO-1:0];
    core_out_en = h[NO+NG-1:NO];
    core_bi_out = h[9:8];
    core_bi_en  = h[11:10];
    bi_in       = h[13:12];
    in_pin      = h[16:14];
  endtask

  // scans w in (bit 0 first) and returns the bits read at tdo; flags pad motion
  task automatic scan(logic [L-1:0] w, output logic [L-1:0] got, output bit moved);
    logic [PW-1:0] start;
    start = pads();
    moved = 1'b0;
    for (int k = 0; k < L; k++) begin
      got[k] = tdo;
      tdi = w[k];
      shf_en = 1'b1;
      tick();
      if (pads() != start) moved = 1'b1;
    end
    shf_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge tck);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [L-1:0] lat, w, got, ecap;
    bit moved;
    trst_n = 1'b0; cap_en = 1'b0; shf_en = 1'b0; upd_en = 1'b0; tdi = 1'b0;
    test_mode = 2'd0;
    set_pins(1);
    repeat (3) tick();
    // R7: reset state in external test
    check(tdo == 1'b0, "R7 tdo in reset", 32'(tdo), 0);
    check(out_oe == '0 && bi_oe == '0, "R7 oe in reset", 32'({out_oe, bi_oe}), 0);
    check(out_pin == '0 && bi_pin_out == '0, "R7 pads in reset", 32'({out_pin, bi_pin_out}), 0);
    trst_n = 1'b1;
    repeat (3) tick();
    check(pads() == exp_pads(ctrl_mask(), 2'd0), "R7 after release",
          32'(pads()), 32'(exp_pads(ctrl_mask(), 2'd0)));
    lat = ctrl_mask();

    for (int m = 0; m < 4; m++) begin
      for (int p = 0; p < 6; p++) begin
        test_mode = 2'(m);
        set_pins(p * 7 + m * 31 + 5);
        #1;
        // R4 R5 R6: pads before any new update
        check(pads() == exp_pads(lat, 2'(m)), "R4/R6 pads pre", 32'(pads()), 32'(exp_pads(lat, 2'(m))));
        ecap = exp_cap();
        cap_en = 1'b1;
        tick();
        cap_en = 1'b0;
        w = L'(mix(p * 13 + m * 101 + 77));
        scan(w, got, moved);
        // R2 R8: captured image read out in order
        check(got == ecap, "R2/R8 capture", 32'(got), 32'(ecap));
        // R3: pads do not follow the shifting chain
        check(!moved && pads() == exp_pads(lat, 2'(m)), "R3 hold during shift",
              32'(pads()), 32'(exp_pads(lat, 2'(m))));
        upd_en = 1'b1;
        tick();
        upd_en = 1'b0;
        lat = w & ((L'(1) << (SPAN + 2 * NB)) - 1);
        // R4 R5 R6: pads after update
        check(pads() == exp_pads(lat, 2'(m)), "R4/R5 pads post", 32'(pads()), 32'(exp_pads(lat, 2'(m))));
      end
    end

    // R6: latch loaded in functional mode appears after switch to external test
    test_mode = 2'd3;
    set_pins(999);
    w = L'(mix(4242));
    scan(w, got, moved);
    upd_en = 1'b1;
    tick();
    upd_en = 1'b0;
    lat = w & ((L'(1) << (SPAN + 2 * NB)) - 1);
    check(pads() == exp_pads(lat, 2'd3), "R6 functional pass", 32'(pads()), 32'(exp_pads(lat, 2'd3)));
    test_mode = 2'd0;
    #1;
    check(pads() == exp_pads(lat, 2'd0), "R6 latch kept", 32'(pads()), 32'(exp_pads(lat, 2'd0)));

    // R1: without capture, the previous chain contents emerge in order
    scan(~w, got, moved);
    check(got == w, "R1 serial order", 32'(got), 32'(w));
    scan(w, got, moved);
    check(got == ~w, "R1 serial order inverse", 32'(got), 32'(~w));

    // R5: one group enabled, other disabled
    w = '1;
    w[p_gctl(0)] = 1'b0;
    scan(w, got, moved);
    upd_en = 1'b1;
    tick();
    upd_en = 1'b0;
    check(out_oe == NO'((1 << GW) - 1), "R5 group enable", 32'(out_oe), (1 << GW) - 1);

    // R7: reset in mid operation
    test_mode = 2'd2;
    #1;
    trst_n = 1'b0;
    #1;
    check(out_oe == '0 && bi_oe == '0 && tdo == 1'b0, "R7 mid reset",
          32'({out_oe, bi_oe, tdo}), 0);
    trst_n = 1'b1;
    repeat (3) tick();
    scan('0, got, moved);
    check(got == '0, "R7 chain cleared", 32'(got), 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule